// File: doc/BRIEF.md
# Multi-Channel Power-Good Monitor

This block merges the voltage status of several regulator channels into one power-good indication. Each channel supplies two comparator bits, already synchronised to the clock. The first says the channel output is at or above the upper threshold (92% of its target). The second says the output is below the lower threshold (88% of its target). Each channel also has an enable flag and a slave flag. A channel in slave mode follows another channel's power stage and has no regulation loop of its own.

Every channel keeps a two-state good/not-good record with hysteresis. The record becomes good on the upper comparator. It becomes not-good only when the lower comparator stays asserted for a blanking window of `BLANK_CYCLES` consecutive clocks, so that short dropouts are ignored. Channels that are disabled or in slave mode are left out of the combination. The registered `pg_ok` output is high only when at least one channel is active and every active channel is good. `pg_pull_low` models the enable of an open-drain pull-down and is the inverse of `pg_ok`.

Top module: `pgmon_top`

## Requirements
- R1: An enabled channel that is not good becomes good at a clock edge where its `cmp_hi` bit is 1. While not good, its `cmp_lo` bit has no effect.
- R2: A good channel stays good at every edge where its `cmp_lo` bit is 0, whatever its `cmp_hi` bit is.
- R3: A good channel becomes not-good only at the edge that completes `BLANK_CYCLES` consecutive edges with its `cmp_lo` bit at 1. Any shorter run of `cmp_lo` leaves it good.
- R4: `pg_ok` is registered. After an edge it is 1 only if, at that edge, at least one channel was active (`ch_en`=1, `ch_slave`=0) and every active channel was already good.
- R5: A channel with `ch_slave`=1 has no effect on `pg_ok`, whatever its state.
- R6: When no channel is active, `pg_ok` is 0 one edge later.
- R7: A channel sampled with `ch_en`=0 becomes not-good. Once enabled again, it needs a new `cmp_hi` before it counts as good.
- R8: `pg_pull_low` is always the inverse of `pg_ok`: 1 asserts the active-low pull-down.
- R9: While `rst_n` is 0, all channels are not-good, `pg_ok` is 0 and `pg_pull_low` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_slave | input | NUM_CH | Per-channel slave-mode flag (1 = masked) |
| cmp_hi | input | NUM_CH | Output at or above upper threshold |
| cmp_lo | input | NUM_CH | Output below lower threshold |
| pg_ok | output | 1 | Combined power-good status |
| pg_pull_low | output | 1 | Open-drain pull-down enable (1 = pull low) |

## Verification
Directed sequences bring a single channel up, then apply lower-comparator runs one cycle shorter than the window and exactly the window length. These two runs separate correct blanking from an off-by-one window or from no blanking at all. Further sequences add an active channel that is not yet good, which distinguishes all-channels combination from any-channel combination. Marking that channel as slave then shows that the mask works, and disabling every channel, then re-enabling without `cmp_hi`, covers the empty-set and restart rules. A long seeded random run mixes enables, slave flags, and bursty comparator patterns, and checks both outputs every cycle against a bench reference model.

// File: rtl/pgmon_pkg.sv
package pgmon_pkg;

   typedef enum logic {
      CH_LOW  = 1'b0,
      CH_GOOD = 1'b1
   } ch_state_e;

   function automatic int unsigned cnt_width(input int unsigned depth);
      cnt_width = (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/pgmon_blank_timer.sv
module pgmon_blank_timer #(
   parameter int unsigned WINDOW = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = pgmon_pkg::cnt_width(WINDOW);

   generate
      if (WINDOW == 1) begin : g_nowin
         assign expired = run && !clr;
      end else begin : g_win
         localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);
         logic [CW-1:0] cnt_q;

         assign expired = run && !clr && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr || !run || expired) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pgmon_channel.sv
module pgmon_channel #(
   parameter int unsigned BLANK_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic above_hi,
   input  logic below_lo,
   output logic good
);
   import pgmon_pkg::*;

   ch_state_e state_q, state_d;
   logic      drop_done;

   pgmon_blank_timer #(.WINDOW(BLANK_CYCLES)) blank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!en || (state_q != CH_GOOD)),
      .run     (below_lo),
      .expired (drop_done)
   );

   always_comb begin
      state_d = state_q;
      if (!en) begin
         state_d = CH_LOW;
      end else begin
         unique case (state_q)
            CH_LOW:  if (above_hi)  state_d = CH_GOOD;
            CH_GOOD: if (drop_done) state_d = CH_LOW;
            default: state_d = CH_LOW;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_LOW;
      end else begin
         state_q <= state_d;
      end
   end

   assign good = (state_q == CH_GOOD);

endmodule

// File: rtl/pgmon_combine.sv
module pgmon_combine #(
   parameter int unsigned NUM_CH  = 3,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] en,
   input  logic [NUM_CH-1:0] slave,
   input  logic [NUM_CH-1:0] good,
   output logic              all_ok
);
   logic [NUM_CH-1:0] active;
   logic [NUM_CH-1:0] pass;
   logic              ok_c;

   assign active = en & ~slave;
   assign pass   = good | ~active;
   assign ok_c   = (|active) && (&pass);

   generate
      if (REG_OUT) begin : g_reg
         logic ok_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ok_q <= 1'b0;
            end else begin
               ok_q <= ok_c;
            end
         end
         assign all_ok = ok_q;
      end else begin : g_comb
         assign all_ok = ok_c && rst_n;
      end
   endgenerate

endmodule

// File: rtl/pgmon_top.sv
module pgmon_top #(
   parameter int unsigned NUM_CH       = 3,
   parameter int unsigned BLANK_CYCLES = 8,
   parameter bit          REG_OUT      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] ch_slave,
   input  logic [NUM_CH-1:0] cmp_hi,
   input  logic [NUM_CH-1:0] cmp_lo,
   output logic              pg_ok,
   output logic              pg_pull_low
);
   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_nch
         $error("pgmon_top: NUM_CH must be within 1..32");
      end
      if (BLANK_CYCLES < 1) begin : g_bad_blank
         $error("pgmon_top: BLANK_CYCLES must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0] ch_good;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pgmon_channel #(.BLANK_CYCLES(BLANK_CYCLES)) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[c]),
            .above_hi (cmp_hi[c]),
            .below_lo (cmp_lo[c]),
            .good     (ch_good[c])
         );
      end
   endgenerate

   pgmon_combine #(.NUM_CH(NUM_CH), .REG_OUT(REG_OUT)) comb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ch_en),
      .slave  (ch_slave),
      .good   (ch_good),
      .all_ok (pg_ok)
   );

   assign pg_pull_low = !pg_ok;

endmodule

// File: rtl/pgmon_chk.sv
module pgmon_chk #(
   parameter int unsigned NUM_CH       = 3,
   parameter int unsigned BLANK_CYCLES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] ch_slave,
   input logic [NUM_CH-1:0] cmp_hi,
   input logic [NUM_CH-1:0] cmp_lo,
   input logic [NUM_CH-1:0] ch_good,
   input logic              pg_ok
);
   localparam int unsigned RW = $clog2(BLANK_CYCLES + 2);
   localparam logic [RW-1:0] RMAX = RW'(BLANK_CYCLES);

   logic [NUM_CH-1:0] act;
   logic [RW-1:0]     lo_run [NUM_CH];

   assign act = ch_en & ~ch_slave;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) lo_run[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (!cmp_lo[i])              lo_run[i] <= '0;
            else if (lo_run[i] != RMAX)  lo_run[i] <= lo_run[i] + 1'b1;
         end
      end
   end

   AST_EMPTY_SET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0) |=> !pg_ok); // R6

   AST_AGGREGATE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_ok) |-> $past((act != '0) && ((ch_good | ~act) == '1))); // R4

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ast
         AST_RISE_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_good[c]) |-> $past(cmp_hi[c] && ch_en[c])); // R1

         AST_HOLD_NO_LO: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_good[c] && ch_en[c] && !cmp_lo[c]) |=> ch_good[c]); // R2

         AST_FALL_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(ch_good[c]) && $past(ch_en[c])) |-> (lo_run[c] >= RW'(BLANK_CYCLES))); // R3

         AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[c] |=> !ch_good[c]); // R7
      end
   endgenerate

endmodule

bind pgmon_top pgmon_chk #(.NUM_CH(NUM_CH), .BLANK_CYCLES(BLANK_CYCLES)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .ch_en    (ch_en),
   .ch_slave (ch_slave),
   .cmp_hi   (cmp_hi),
   .cmp_lo   (cmp_lo),
   .ch_good  (ch_good),
   .pg_ok    (pg_ok)
);

// File: tb/pgmon_top_tb_top.sv
module pgmon_top_tb_top;
   localparam int  CLK_PERIOD = 10;
   localparam int  NCH        = 3;
   localparam int  BLANK      = 5;
   localparam int  RAND_CYC   = 4000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] ch_en = '0, ch_slave = '0, cmp_hi = '0, cmp_lo = '0;
   logic           pg_ok, pg_pull_low;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state, built from the requirements
   logic [NCH-1:0] good_m = '0;
   int             cnt_m [NCH];
   logic           pg_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgmon_top #(.NUM_CH(NCH), .BLANK_CYCLES(BLANK)) dut_i (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_slave(ch_slave),
      .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .pg_ok(pg_ok), .pg_pull_low(pg_pull_low)
   );

   function automatic logic exp_pg(input logic [NCH-1:0] g, input logic [NCH-1:0] en,
                                   input logic [NCH-1:0] sl);
      logic [NCH-1:0] a;
      a = en & ~sl;
      return (a != '0) && ((g | ~a) == '1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_m <= '0;
         pg_m   <= 1'b0;
         for (int i = 0; i < NCH; i++) cnt_m[i] <= 0;
      end else begin
         pg_m <= exp_pg(good_m, ch_en, ch_slave);
         for (int i = 0; i < NCH; i++) begin
            if (!ch_en[i]) begin
               good_m[i] <= 1'b0; cnt_m[i] <= 0;
            end else if (!good_m[i]) begin
               good_m[i] <= cmp_hi[i]; cnt_m[i] <= 0;
            end else if (cmp_lo[i]) begin
               if (cnt_m[i] == BLANK - 1) begin
                  good_m[i] <= 1'b0; cnt_m[i] <= 0;
               end else begin
                  cnt_m[i] <= cnt_m[i] + 1;
               end
            end else begin
               cnt_m[i] <= 0;
            end
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_out(input logic exp, input string req);
      chk(pg_ok, exp, req);
      chk(pg_pull_low, !exp, "R8");
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      step(2);
      chk_out(1'b0, "R9");                         // reset state
      rst_n = 1'b1;
      ch_en = 3'b001;
      step(3);
      chk_out(1'b0, "R1");                         // no cmp_hi yet
      cmp_lo = 3'b001;                             // lo ignored while not good
      step(2);
      chk_out(1'b0, "R1");
      cmp_lo = '0;
      cmp_hi = 3'b001;
      step(1);
      cmp_hi = '0;
      step(1);
      chk_out(1'b1, "R1");                         // good, combined up
      cmp_hi = 3'b001;
      step(3);
      chk_out(1'b1, "R2");                         // stays good with lo low
      cmp_hi = '0;
      cmp_lo = 3'b001;
      step(BLANK - 1);
      cmp_lo = '0;
      step(2);
      chk_out(1'b1, "R3");                         // short drop blanked
      cmp_lo = 3'b001;
      step(BLANK);
      chk_out(1'b1, "R3");                         // pg lags by one edge
      step(1);
      chk_out(1'b0, "R3");                         // full window clears
      cmp_lo = '0;
      cmp_hi = 3'b001;
      step(1);
      cmp_hi = '0;
      step(1);
      chk_out(1'b1, "R1");
      ch_en = 3'b011;                              // ch1 active, not good
      step(1);
      chk_out(1'b0, "R4");
      ch_slave = 3'b010;                           // mask ch1
      step(1);
      chk_out(1'b1, "R5");
      ch_en = '0;
      step(1);
      chk_out(1'b0, "R6");
      ch_slave = '0;
      ch_en = 3'b001;
      step(3);
      chk_out(1'b0, "R7");                         // needs a fresh cmp_hi
      cmp_hi = 3'b001;
      step(2);
      chk_out(1'b1, "R7");
      cmp_hi = '0;

      // seeded random phase against the reference model
      for (int k = 0; k < RAND_CYC; k++) begin
         ch_en    = ((k % 300) < 20) ? NCH'($urandom) :
                    (NCH'($urandom) | NCH'($urandom) | NCH'($urandom));
         if ((k % 50) == 0) ch_slave = NCH'($urandom) & NCH'($urandom);
         cmp_hi   = NCH'($urandom) & NCH'($urandom);
         for (int i = 0; i < NCH; i++) begin
            if (($urandom % 5) == 0) cmp_lo[i] = ~cmp_lo[i];
         end
         step(1);
         chk_out(pg_m, "R4");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule